// File: doc/BRIEF.md
# Analog-Output Card Register Decoder

This block decodes a 32-byte, byte-addressed I/O window for an analog-output card. It holds three configuration words, a sticky flag bank for two interrupt sources and a terminal-count event, an 8-line digital port with direction set per half, and a latch for each DAC channel. It also produces strobes toward an external interval timer and an external sample FIFO. The converters, the timer, DMA and the FIFO storage sit outside the block. The FIFO and timer connect through ports only.

Bit 7 of the first configuration word selects a second write group. While that bit is set, writes to the three lowest word offsets stop reaching the data-out register and the second and third configuration words. They become clear strobes for the flags instead. Reading the FIFO offset returns zero and sends a one-cycle clear pulse to the FIFO.

Top module: `aout_port_regs`

## Requirements
- R1: After reset, all three configuration outputs are 0, the digital outputs and their enables are 0, every flag is clear, and the DAC latches and the read data are 0.
- R2: With the group bit (cfg1 bit 7) clear, a write to 0x0A, 0x02 or 0x04 loads cfg1, cfg2 or cfg3 with the full 16-bit word. A write to 0x0A always reaches cfg1, whatever the group bit. Each value appears on its output one cycle after the write.
- R3: With the group bit set, a write to 0x00, 0x02 or 0x04 clears, on the next cycle, the terminal-count, interrupt-1 or interrupt-2 flag respectively, whatever the data. The data-out register, cfg2 and cfg3 keep their values.
- R4: An event input sets its flag on the next clock, and the flag stays set until it is cleared. An event in the same cycle as a clear of its flag leaves the flag set.
- R5: A read of 0x0A returns the status word: bit 6 FIFO half, bit 5 FIFO empty, bit 4 FIFO full, bit 3 interrupt-2 flag, bit 2 interrupt-1 flag, bit 1 terminal-count flag, bit 0 PROM serial bit. The other bits read 0.
- R6: A write to 0x00 loads the low 8 bits into the digital output register. cfg3 bit 2 drives lines 0-3 and cfg3 bit 3 drives lines 4-7. A read of 0x00 returns, for each line, the output register bit when the line is driven and the pin when it is not.
- R7: A read of 0x0C returns 0 and raises fifo_clr_o for exactly one cycle, in the cycle after the read.
- R8: A write to 0x0C with cfg1 bit 8 set pulses fifo_wr_o for one cycle and presents the written word on fifo_wdata_o. The DAC latches do not load. With cfg1 bit 8 clear, the write goes to DAC channel 0.
- R9: A write to 0x0C + 2n, for n below DAC_CH, loads the low 12 bits into DAC channel n and pulses that channel's load bit for one cycle. No more than one load bit is ever high.
- R10: Reads of the write-only offsets (0x02, 0x04, DAC offsets above 0x0C) and of unmapped offsets return 0. Writes to unmapped odd offsets change nothing.
- R11: Offsets 0x06 to 0x09 reach the timer. tmr_wr_o or tmr_rd_o is high in the same cycle as the bus access, with tmr_idx_o equal to the offset minus 6 and tmr_wdata_o carrying the low data byte. A timer read returns tmr_rdata_i in the low byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_wr_i | input | 1 | Write strobe, one cycle per access |
| bus_rd_i | input | 1 | Read strobe, one cycle per access |
| bus_addr_i | input | 5 | Byte offset in the window |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data, registered, held until the next read |
| dio_pin_i | input | 8 | Digital port pin levels |
| dio_out_o | output | 8 | Digital output register |
| dio_oe_o | output | 8 | Digital output enables, one per line |
| fifo_half_i | input | 1 | FIFO half-full flag |
| fifo_empty_i | input | 1 | FIFO empty flag |
| fifo_full_i | input | 1 | FIFO full flag |
| prom_bit_i | input | 1 | PROM serial output bit |
| irq1_evt_i | input | 1 | Interrupt-1 event |
| irq2_evt_i | input | 1 | Interrupt-2 event |
| tc_evt_i | input | 1 | Terminal-count event |
| cfg1_o | output | 16 | Configuration word 1 |
| cfg2_o | output | 16 | Configuration word 2 |
| cfg3_o | output | 16 | Configuration word 3 |
| fifo_wr_o | output | 1 | FIFO write pulse |
| fifo_wdata_o | output | 16 | FIFO write data |
| fifo_clr_o | output | 1 | FIFO clear pulse |
| dac_load_o | output | DAC_CH | Per-channel load pulse |
| dac_data_o | output | DAC_CH*12 | Per-channel latched code, channel n at bits 12n+11:12n |
| tmr_wr_o | output | 1 | Timer byte write strobe |
| tmr_rd_o | output | 1 | Timer byte read strobe |
| tmr_idx_o | output | 2 | Timer byte index |
| tmr_wdata_o | output | 8 | Timer write byte |
| tmr_rdata_i | input | 8 | Timer read byte |

## Verification
Register writes, flag set and clear, DAC loads and FIFO write pulses take effect on the clock edge that samples the write. They are due one cycle after the strobe. Read data and the FIFO clear pulse are also registered and appear one cycle after the read strobe. The timer strobes are combinational and are due in the same cycle. The bench drives every access on the falling edge and checks registered results on the next falling edge. It checks timer strobes while the access is still being driven, and checks that pulses drop again one further falling edge later.

// File: rtl/aout_regs_pkg.sv
package aout_regs_pkg;
  localparam logic [4:0] OFS_DIO    = 5'h00;
  localparam logic [4:0] OFS_CFG2   = 5'h02;
  localparam logic [4:0] OFS_CFG3   = 5'h04;
  localparam logic [4:0] OFS_TMR_LO = 5'h06;
  localparam logic [4:0] OFS_TMR_HI = 5'h09;
  localparam logic [4:0] OFS_CFG1   = 5'h0A;
  localparam logic [4:0] OFS_FIFO   = 5'h0C;

  localparam int unsigned GRP2_BIT    = 7;
  localparam int unsigned FIFO_EN_BIT = 8;
  localparam int unsigned OE_LO_BIT   = 2;
  localparam int unsigned OE_HI_BIT   = 3;

  localparam int unsigned FLG_TC = 0;
  localparam int unsigned FLG_I1 = 1;
  localparam int unsigned FLG_I2 = 2;
  localparam int unsigned N_FLG  = 3;

  typedef struct packed {
    logic             wr_dout;
    logic             wr_cfg1;
    logic             wr_cfg2;
    logic             wr_cfg3;
    logic             wr_fifo;
    logic             wr_tmr;
    logic             rd_din;
    logic             rd_stat;
    logic             rd_fifo;
    logic             rd_tmr;
    logic [N_FLG-1:0] clr;
  } dec_t;
endpackage

// File: rtl/aout_addr_dec.sv
module aout_addr_dec
  import aout_regs_pkg::*;
#(
  parameter int unsigned DAC_CH = 10
) (
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [4:0]        addr_i,
  input  logic              grp2_i,
  input  logic              fifo_en_i,
  output dec_t              dec_o,
  output logic [DAC_CH-1:0] dac_wr_o
);
  logic tmr_hit;
  assign tmr_hit = (addr_i >= OFS_TMR_LO) && (addr_i <= OFS_TMR_HI);

  always_comb begin
    dec_o = '0;
    if (wr_i) begin
      case (addr_i)
        OFS_DIO:  if (grp2_i) dec_o.clr[FLG_TC] = 1'b1; else dec_o.wr_dout = 1'b1;
        OFS_CFG2: if (grp2_i) dec_o.clr[FLG_I1] = 1'b1; else dec_o.wr_cfg2 = 1'b1;
        OFS_CFG3: if (grp2_i) dec_o.clr[FLG_I2] = 1'b1; else dec_o.wr_cfg3 = 1'b1;
        OFS_CFG1: dec_o.wr_cfg1 = 1'b1;
        OFS_FIFO: dec_o.wr_fifo = fifo_en_i;
        default:  ;
      endcase
      dec_o.wr_tmr = tmr_hit;
    end
    if (rd_i) begin
      case (addr_i)
        OFS_DIO:  dec_o.rd_din  = 1'b1;
        OFS_CFG1: dec_o.rd_stat = 1'b1;
        OFS_FIFO: dec_o.rd_fifo = 1'b1;
        default:  ;
      endcase
      dec_o.rd_tmr = tmr_hit;
    end
  end

  // channel 0 shares the FIFO offset; FIFO enable steers it away
  for (genvar i = 0; i < DAC_CH; i++) begin : g_dac_dec
    localparam int unsigned OFS = 12 + 2 * i;
    if (i == 0) begin : g_ch0
      assign dac_wr_o[i] = wr_i && (addr_i == 5'(OFS)) && !fifo_en_i;
    end else begin : g_chn
      assign dac_wr_o[i] = wr_i && (addr_i == 5'(OFS));
    end
  end
endmodule

// File: rtl/aout_flag_bank.sv
module aout_flag_bank #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       flag_o[i] <= 1'b0;
      else if (set_i[i]) flag_o[i] <= 1'b1;
      else if (clr_i[i]) flag_o[i] <= 1'b0;
    end

    p_set_wins_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[i] |=> flag_o[i]);
    p_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[i] && !set_i[i]) |=> !flag_o[i]);
    p_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_o[i] && !clr_i[i]) |=> flag_o[i]);
  end
endmodule

// File: rtl/aout_dio_port.sv
module aout_dio_port #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         oe_lo_i,
  input  logic         oe_hi_i,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] out_o,
  output logic [W-1:0] oe_o,
  output logic [W-1:0] rd_o
);
  localparam int unsigned HALF = W / 2;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   out_o <= '0;
    else if (wr_i) out_o <= wdata_i;
  end

  for (genvar i = 0; i < W; i++) begin : g_line
    if (i < HALF) begin : g_lo
      assign oe_o[i] = oe_lo_i;
    end else begin : g_hi
      assign oe_o[i] = oe_hi_i;
    end
    assign rd_o[i] = oe_o[i] ? out_o[i] : pin_i[i];
  end

  p_dout_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> out_o == $past(wdata_i));
  p_dout_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(out_o));
endmodule

// File: rtl/aout_dac_bank.sv
module aout_dac_bank #(
  parameter int unsigned N     = 10,
  parameter int unsigned DAC_W = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N-1:0]       wr_i,
  input  logic [DAC_W-1:0]   wdata_i,
  output logic [N-1:0]       load_o,
  output logic [N*DAC_W-1:0] data_o
);
  for (genvar i = 0; i < N; i++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        data_o[i*DAC_W +: DAC_W] <= '0;
        load_o[i]                <= 1'b0;
      end else begin
        load_o[i] <= wr_i[i];
        if (wr_i[i]) data_o[i*DAC_W +: DAC_W] <= wdata_i;
      end
    end

    p_dac_load_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_i[i] |=> load_o[i] && (data_o[i*DAC_W +: DAC_W] == $past(wdata_i)));
  end

  p_dac_onehot_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(load_o));
endmodule

// File: rtl/aout_port_regs.sv
module aout_port_regs
  import aout_regs_pkg::*;
#(
  parameter int unsigned DAC_CH = 10,
  parameter int unsigned DAC_W  = 12,
  parameter int unsigned DIO_W  = 8,
  parameter int unsigned DATA_W = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    bus_wr_i,
  input  logic                    bus_rd_i,
  input  logic [4:0]              bus_addr_i,
  input  logic [DATA_W-1:0]       bus_wdata_i,
  output logic [DATA_W-1:0]       bus_rdata_o,
  input  logic [DIO_W-1:0]        dio_pin_i,
  output logic [DIO_W-1:0]        dio_out_o,
  output logic [DIO_W-1:0]        dio_oe_o,
  input  logic                    fifo_half_i,
  input  logic                    fifo_empty_i,
  input  logic                    fifo_full_i,
  input  logic                    prom_bit_i,
  input  logic                    irq1_evt_i,
  input  logic                    irq2_evt_i,
  input  logic                    tc_evt_i,
  output logic [DATA_W-1:0]       cfg1_o,
  output logic [DATA_W-1:0]       cfg2_o,
  output logic [DATA_W-1:0]       cfg3_o,
  output logic                    fifo_wr_o,
  output logic [DATA_W-1:0]       fifo_wdata_o,
  output logic                    fifo_clr_o,
  output logic [DAC_CH-1:0]       dac_load_o,
  output logic [DAC_CH*DAC_W-1:0] dac_data_o,
  output logic                    tmr_wr_o,
  output logic                    tmr_rd_o,
  output logic [1:0]              tmr_idx_o,
  output logic [7:0]              tmr_wdata_o,
  input  logic [7:0]              tmr_rdata_i
);
  dec_t               dec;
  logic [DAC_CH-1:0]  dac_wr;
  logic [N_FLG-1:0]   flag;
  logic [N_FLG-1:0]   flag_set;
  logic [DIO_W-1:0]   dio_rd;
  logic [DATA_W-1:0]  status;
  logic [DATA_W-1:0]  rd_val;

  aout_addr_dec #(.DAC_CH(DAC_CH)) u_dec (
    .wr_i      (bus_wr_i),
    .rd_i      (bus_rd_i),
    .addr_i    (bus_addr_i),
    .grp2_i    (cfg1_o[GRP2_BIT]),
    .fifo_en_i (cfg1_o[FIFO_EN_BIT]),
    .dec_o     (dec),
    .dac_wr_o  (dac_wr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg1_o <= '0;
      cfg2_o <= '0;
      cfg3_o <= '0;
    end else begin
      if (dec.wr_cfg1) cfg1_o <= bus_wdata_i;
      if (dec.wr_cfg2) cfg2_o <= bus_wdata_i;
      if (dec.wr_cfg3) cfg3_o <= bus_wdata_i;
    end
  end

  assign flag_set[FLG_TC] = tc_evt_i;
  assign flag_set[FLG_I1] = irq1_evt_i;
  assign flag_set[FLG_I2] = irq2_evt_i;

  aout_flag_bank #(.N(N_FLG)) u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (flag_set),
    .clr_i  (dec.clr),
    .flag_o (flag)
  );

  aout_dio_port #(.W(DIO_W)) u_dio (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (dec.wr_dout),
    .wdata_i (bus_wdata_i[DIO_W-1:0]),
    .oe_lo_i (cfg3_o[OE_LO_BIT]),
    .oe_hi_i (cfg3_o[OE_HI_BIT]),
    .pin_i   (dio_pin_i),
    .out_o   (dio_out_o),
    .oe_o    (dio_oe_o),
    .rd_o    (dio_rd)
  );

  aout_dac_bank #(.N(DAC_CH), .DAC_W(DAC_W)) u_dac (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (dac_wr),
    .wdata_i (bus_wdata_i[DAC_W-1:0]),
    .load_o  (dac_load_o),
    .data_o  (dac_data_o)
  );

  // timer is external; strobes pass straight through
  assign tmr_wr_o    = dec.wr_tmr;
  assign tmr_rd_o    = dec.rd_tmr;
  assign tmr_idx_o   = 2'(bus_addr_i - OFS_TMR_LO);
  assign tmr_wdata_o = bus_wdata_i[7:0];

  assign status = DATA_W'({fifo_half_i, fifo_empty_i, fifo_full_i,
                           flag[FLG_I2], flag[FLG_I1], flag[FLG_TC], prom_bit_i});

  always_comb begin
    rd_val = '0;
    if (dec.rd_din)  rd_val = DATA_W'(dio_rd);
    if (dec.rd_stat) rd_val = status;
    if (dec.rd_tmr)  rd_val = DATA_W'(tmr_rdata_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bus_rdata_o  <= '0;
      fifo_clr_o   <= 1'b0;
      fifo_wr_o    <= 1'b0;
      fifo_wdata_o <= '0;
    end else begin
      if (bus_rd_i) bus_rdata_o <= rd_val;
      fifo_clr_o <= dec.rd_fifo;
      fifo_wr_o  <= dec.wr_fifo;
      if (dec.wr_fifo) fifo_wdata_o <= bus_wdata_i;
    end
  end

  p_cfg1_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && bus_addr_i == OFS_CFG1) |=> cfg1_o == $past(bus_wdata_i));
  p_grp2_cfg2_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && bus_addr_i == OFS_CFG2 && cfg1_o[GRP2_BIT]) |=> $stable(cfg2_o));
  p_grp2_cfg3_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && bus_addr_i == OFS_CFG3 && cfg1_o[GRP2_BIT]) |=> $stable(cfg3_o));
  p_fifo_clr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rd_i && bus_addr_i == OFS_FIFO) |=> fifo_clr_o && bus_rdata_o == '0);
  p_fifo_clr_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_rd_i && bus_addr_i == OFS_FIFO) |=> !fifo_clr_o);
  p_fifo_wr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && bus_addr_i == OFS_FIFO && cfg1_o[FIFO_EN_BIT])
      |=> fifo_wr_o && dac_load_o == '0);
endmodule

// File: tb/aout_port_regs_bench.sv
module aout_port_regs_bench;
  localparam int unsigned DAC_CH = 10;
  localparam int unsigned DAC_W  = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [4:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [7:0]  pins = 8'h3C;
  logic [7:0]  dout, doe;
  logic        f_half = 1'b0, f_empty = 1'b0, f_full = 1'b0, prom = 1'b0;
  logic        ev1 = 1'b0, ev2 = 1'b0, evtc = 1'b0;
  logic [15:0] cfg1, cfg2, cfg3;
  logic        fwr, fclr;
  logic [15:0] fwdata;
  logic [DAC_CH-1:0]       dload;
  logic [DAC_CH*DAC_W-1:0] ddata;
  logic        twr, trd;
  logic [1:0]  tidx;
  logic [7:0]  twdata;
  logic [7:0]  trdata = 8'h00;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  aout_port_regs #(.DAC_CH(DAC_CH), .DAC_W(DAC_W)) u_aout_port_regs (
    .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(wr), .bus_rd_i(rd),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .dio_pin_i(pins), .dio_out_o(dout), .dio_oe_o(doe),
    .fifo_half_i(f_half), .fifo_empty_i(f_empty), .fifo_full_i(f_full),
    .prom_bit_i(prom), .irq1_evt_i(ev1), .irq2_evt_i(ev2), .tc_evt_i(evtc),
    .cfg1_o(cfg1), .cfg2_o(cfg2), .cfg3_o(cfg3),
    .fifo_wr_o(fwr), .fifo_wdata_o(fwdata), .fifo_clr_o(fclr),
    .dac_load_o(dload), .dac_data_o(ddata),
    .tmr_wr_o(twr), .tmr_rd_o(trd), .tmr_idx_o(tidx),
    .tmr_wdata_o(twdata), .tmr_rdata_i(trdata)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one-cycle write; returns on the falling edge after the sampling edge
  task automatic bus_write(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_read(input logic [4:0] a);
    @(negedge clk);
    rd = 1'b1; addr = a;
    @(negedge clk);
    rd = 1'b0;
  endtask

  // {write addr, write data, read addr, expected read}
  localparam logic [41:0] VEC [8] = '{
    {5'h00, 16'h00A5, 5'h00, 16'h003C},  // R6 both halves input
    {5'h04, 16'h000C, 5'h00, 16'h00A5},  // R6 both halves driven
    {5'h04, 16'h0004, 5'h00, 16'h0035},  // R6 low half driven
    {5'h04, 16'h0008, 5'h00, 16'h00AC},  // R6 high half driven
    {5'h02, 16'h1234, 5'h02, 16'h0000},  // R10 cfg2 write-only
    {5'h12, 16'h0ABC, 5'h12, 16'h0000},  // R10 DAC3 write-only
    {5'h0B, 16'hFFFF, 5'h0B, 16'h0000},  // R10 odd offset
    {5'h04, 16'h0000, 5'h0A, 16'h0051}   // R5 status inputs
  };

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 cfg1", 32'(cfg1), 0);
    check("R1 cfg2", 32'(cfg2), 0);
    check("R1 cfg3", 32'(cfg3), 0);
    check("R1 doe", 32'(doe), 0);
    check("R1 dout", 32'(dout), 0);
    check("R1 rdata", 32'(rdata), 0);
    check("R1 dac", 32'(ddata[31:0]), 0);
    rst_n = 1'b1;
    bus_read(5'h0A);
    check("R1 flags clear", 32'(rdata), 0);

    f_half = 1'b1; f_full = 1'b1; prom = 1'b1;
    for (int i = 0; i < 8; i++) begin
      bus_write(VEC[i][41:37], VEC[i][36:21]);
      bus_read(VEC[i][20:16]);
      check($sformatf("R5/R6/R10 vec%0d", i), 32'(rdata), 32'(VEC[i][15:0]));
    end
    f_half = 1'b0; f_full = 1'b0; prom = 1'b0;
    check("R2 cfg2 loaded", 32'(cfg2), 32'h1234);
    check("R9 dac3", 32'(ddata[3*DAC_W +: DAC_W]), 32'hABC);
    check("R10 odd write ignored", 32'(cfg1), 0);

    // R2 cfg1 write, read returns status
    bus_write(5'h0A, 16'h0103);
    check("R2 cfg1", 32'(cfg1), 32'h0103);
    bus_read(5'h0A);
    check("R2 cfg1 reads status", 32'(rdata), 0);

    // R8 FIFO write with FIFO enable
    bus_write(5'h0C, 16'h5A5A);
    check("R8 fifo_wr", 32'(fwr), 1);
    check("R8 fifo data", 32'(fwdata), 32'h5A5A);
    check("R8 no dac load", 32'(dload), 0);
    @(negedge clk);
    check("R8 fifo_wr drop", 32'(fwr), 0);
    bus_write(5'h0A, 16'h0000);
    bus_write(5'h0C, 16'h0123);
    check("R8 dac0 load", 32'(dload), 1);
    check("R8 dac0 data", 32'(ddata[DAC_W-1:0]), 32'h123);
    check("R8 no fifo_wr", 32'(fwr), 0);

    // R9 last channel
    bus_write(5'h1E, 16'hF789);
    check("R9 dac9 load", 32'(dload), 32'h200);
    check("R9 dac9 data", 32'(ddata[9*DAC_W +: DAC_W]), 32'h789);
    @(negedge clk);
    check("R9 load drop", 32'(dload), 0);

    // R7 FIFO clear
    bus_read(5'h0C);
    check("R7 clr pulse", 32'(fclr), 1);
    check("R7 rdata zero", 32'(rdata), 0);
    @(negedge clk);
    check("R7 clr one cycle", 32'(fclr), 0);

    // R4 flags
    @(negedge clk); ev1 = 1'b1;
    @(negedge clk); ev1 = 1'b0;
    repeat (2) @(negedge clk);
    bus_read(5'h0A);
    check("R4 int1 sticky", 32'(rdata), 32'h4);
    @(negedge clk); ev2 = 1'b1; evtc = 1'b1;
    @(negedge clk); ev2 = 1'b0; evtc = 1'b0;
    bus_read(5'h0A);
    check("R4 all flags", 32'(rdata), 32'hE);

    // R3 group-2 clears
    bus_write(5'h0A, 16'h0080);
    bus_write(5'h02, 16'hFFFF);
    check("R3 cfg2 kept", 32'(cfg2), 32'h1234);
    bus_read(5'h0A);
    check("R3 int1 cleared", 32'(rdata), 32'hA);
    bus_write(5'h04, 16'h0000);
    check("R3 cfg3 kept", 32'(cfg3), 0);
    bus_read(5'h0A);
    check("R3 int2 cleared", 32'(rdata), 32'h2);
    @(negedge clk);
    wr = 1'b1; addr = 5'h00; wdata = 16'h00FF; evtc = 1'b1;
    @(negedge clk);
    wr = 1'b0; evtc = 1'b0;
    check("R3 dout kept", 32'(dout), 32'hA5);
    bus_read(5'h0A);
    check("R4 set wins over clear", 32'(rdata), 32'h2);
    bus_write(5'h00, 16'h0000);
    bus_read(5'h0A);
    check("R3 tc cleared", 32'(rdata), 0);
    bus_write(5'h0A, 16'h0000);
    check("R2 cfg1 writable in group 2", 32'(cfg1), 0);

    // R11 timer pass-through
    @(negedge clk);
    wr = 1'b1; addr = 5'h08; wdata = 16'h1177;
    #1;
    check("R11 tmr_wr", 32'(twr), 1);
    check("R11 tmr_idx wr", 32'(tidx), 2);
    check("R11 tmr_wdata", 32'(twdata), 32'h77);
    @(negedge clk);
    wr = 1'b0; rd = 1'b1; addr = 5'h07; trdata = 8'h9C;
    #1;
    check("R11 tmr_rd", 32'(trd), 1);
    check("R11 tmr_idx rd", 32'(tidx), 1);
    @(negedge clk);
    rd = 1'b0;
    check("R11 tmr rdata", 32'(rdata), 32'h9C);

    finish_run();
  end
endmodule